// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block chooses which of twenty-four peripheral interrupt requests the processor takes next. Each source has a 2-bit urgency level, held in six byte-wide level registers. Level 0 is the most urgent and level 3 means the source is never taken. The processor's status carries a global enable bit and a current-level field. A request is taken only when the enable bit is set and the request's level is numerically below the current level. Interrupt service therefore nests only toward more urgent work.

When a request is taken, the block gives a one-cycle take pulse with the winning source index and its level. In the same cycle it pushes the current status (enable and level) onto an internal nesting stack, and it loads the winner's level into the current-level field. A return strobe pops the stack and restores the interrupted status. Software can also overwrite the status directly, for example to block nesting by writing level 0 or clearing the enable bit.

Top module: `nic_top`

## Requirements
- R1: After reset every level field reads 3, the enable bit is 0, the current level is 3, the stack is empty, the overflow flag is 0 and no take occurs.
- R2: Level register k (address 0..5) holds the fields of sources 4k..4k+3. Source 4k+j occupies bits [2j+1:2j]. The register reads back combinationally. At addresses 6 and 7 reads return 0 and writes change no register.
- R3: A source whose level field is 3 is never taken, whatever the status.
- R4: A take requires the enable bit to be 1 and the request's level to be numerically below the current level.
- R5: Among qualifying pending requests, the lowest level wins. A tie goes to the lowest source index.
- R6: On a take, the current level becomes the winner's level from the next cycle, the enable bit is unchanged, and the stack depth grows by one. A request that stays asserted is not taken again at its own level.
- R7: A return strobe pops the stack and restores the saved enable bit and level. A return with an empty stack changes nothing.
- R8: A push while the stack is full sets a sticky overflow flag, which only reset clears. The depth and the stored entries stay unchanged, and the status is still updated.
- R9: A status write loads the enable bit and level and takes precedence over a return in the same cycle. No take occurs in a cycle with a status write or a return strobe.
- R10: A current level of 0 blocks all takes, even those of level-0 sources.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 3 | Level register address |
| reg_wr | input | 1 | Level register write enable |
| reg_wdata | input | 8 | Level register write data |
| reg_rdata | output | 8 | Level register read data |
| irq_req | input | 24 | Level-sensitive request lines, one per source |
| st_wr | input | 1 | Status write strobe |
| st_ien | input | 1 | Enable bit value for a status write |
| st_lvl | input | 2 | Level value for a status write |
| irq_ret | input | 1 | Return-from-interrupt strobe |
| take | output | 1 | One-cycle acceptance pulse |
| take_idx | output | 5 | Index of the accepted source |
| take_level | output | 2 | Level of the accepted source |
| cur_ien | output | 1 | Current global enable bit |
| cur_lvl | output | 2 | Current status level |
| nest_depth | output | 3 | Number of saved status entries |
| stack_ovf | output | 1 | Sticky nesting-stack overflow flag |

## Verification
The assertions assume that the peripheral holds each request until software clears it. They also assume that the return strobe and status writes are single-cycle pulses that arrive in step with the clock. The bench drives every input just after the falling edge. It raises return and status strobes for exactly one cycle and holds requests steady across each decision. For the overflow test it lowers the status by software writes rather than by inventing extra levels, so the stack reaches its limit using only legal entries.

// File: rtl/nic_pkg.sv
package nic_pkg;
   localparam int LVL_W   = 2;
   localparam int FIELDS  = 4;
   localparam int REG_W   = LVL_W * FIELDS;

   typedef struct packed {
      logic             ien;
      logic [LVL_W-1:0] lvl;
   } nic_status_t;
endpackage

// File: rtl/nic_regfile.sv
module nic_regfile #(
   parameter int NUM_REGS = 6,
   parameter int ADDR_W   = 3,
   localparam int LW      = nic_pkg::LVL_W,
   localparam int FLD     = nic_pkg::FIELDS,
   localparam int DW      = nic_pkg::REG_W,
   localparam int NSRC    = NUM_REGS * FLD
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr,
   input  logic [DW-1:0]     wdata,
   output logic [DW-1:0]     rdata,
   output logic [NSRC*LW-1:0] levels
);
   logic [NUM_REGS*DW-1:0] flat;

   for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
      logic [DW-1:0] q;
      always_ff @(posedge clk) begin
         if (!rst_n)
            q <= '1;
         else if (wr && addr == ADDR_W'(r))
            q <= wdata;
      end
      assign flat[r*DW +: DW] = q;
      for (genvar f = 0; f < FLD; f++) begin : g_fld
         assign levels[(r*FLD+f)*LW +: LW] = q[f*LW +: LW];
      end
   end

   always_comb begin
      rdata = '0;
      for (int r = 0; r < NUM_REGS; r++) begin
         if (addr == ADDR_W'(r))
            rdata = flat[r*DW +: DW];
      end
   end
endmodule

// File: rtl/nic_arbiter.sv
module nic_arbiter #(
   parameter int NSRC  = 24,
   localparam int LW   = nic_pkg::LVL_W,
   localparam int IDXW = $clog2(NSRC)
) (
   input  logic [NSRC-1:0]    req,
   input  logic [NSRC*LW-1:0] levels,
   output logic               found,
   output logic [IDXW-1:0]    win_idx,
   output logic [LW-1:0]      win_lvl
);
   localparam logic [LW-1:0] NEVER = '1;
   logic [LW-1:0] lv;

   always_comb begin
      found   = 1'b0;
      win_idx = '0;
      win_lvl = NEVER;
      lv      = '0;
      for (int i = 0; i < NSRC; i++) begin
         lv = levels[i*LW +: LW];
         if (req[i] && lv != NEVER && (!found || lv < win_lvl)) begin
            found   = 1'b1;
            win_lvl = lv;
            win_idx = IDXW'(i);
         end
      end
   end
endmodule

// File: rtl/nic_stack.sv
module nic_stack #(
   parameter int DEPTH = 4,
   parameter int W     = 3,
   localparam int CW   = $clog2(DEPTH+1),
   localparam int PW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic          pop,
   input  logic [W-1:0]  din,
   output logic [W-1:0]  dout,
   output logic [CW-1:0] depth,
   output logic          ovf
);
   logic [W-1:0]  mem [DEPTH];
   logic [CW-1:0] cnt;
   logic          full, empty;

   assign full  = (cnt == CW'(DEPTH));
   assign empty = (cnt == '0);
   assign depth = cnt;
   assign dout  = empty ? '0 : mem[PW'(cnt - CW'(1))];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= '0;
         ovf <= 1'b0;
      end else if (push) begin
         if (full) begin
            ovf <= 1'b1;
         end else begin
            mem[PW'(cnt)] <= din;
            cnt           <= cnt + CW'(1);
         end
      end else if (pop && !empty) begin
         cnt <= cnt - CW'(1);
      end
   end
endmodule

// File: rtl/nic_top.sv
module nic_top #(
   parameter int NUM_REGS    = 6,
   parameter int STACK_DEPTH = 4,
   localparam int LW         = nic_pkg::LVL_W,
   localparam int DW         = nic_pkg::REG_W,
   localparam int NSRC       = NUM_REGS * nic_pkg::FIELDS,
   localparam int ADDR_W     = $clog2(NUM_REGS) < 1 ? 1 : $clog2(NUM_REGS),
   localparam int IDXW       = $clog2(NSRC),
   localparam int DEPW       = $clog2(STACK_DEPTH+1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_wr,
   input  logic [DW-1:0]     reg_wdata,
   output logic [DW-1:0]     reg_rdata,
   input  logic [NSRC-1:0]   irq_req,
   input  logic              st_wr,
   input  logic              st_ien,
   input  logic [LW-1:0]     st_lvl,
   input  logic              irq_ret,
   output logic              take,
   output logic [IDXW-1:0]   take_idx,
   output logic [LW-1:0]     take_level,
   output logic              cur_ien,
   output logic [LW-1:0]     cur_lvl,
   output logic [DEPW-1:0]   nest_depth,
   output logic              stack_ovf
);
   import nic_pkg::*;

   if (STACK_DEPTH < 2) begin : g_bad_depth
      $error("nic_top: STACK_DEPTH must be at least 2");
   end
   if (NUM_REGS < 1) begin : g_bad_regs
      $error("nic_top: NUM_REGS must be at least 1");
   end

   logic [NSRC*LW-1:0] levels;
   logic               found;
   logic [IDXW-1:0]    win_idx;
   logic [LW-1:0]      win_lvl;
   nic_status_t        status, saved;
   logic [2+LW-1:0]    saved_raw;
   logic               qualify, do_pop;

   nic_regfile #(.NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .addr(reg_addr), .wr(reg_wr),
      .wdata(reg_wdata), .rdata(reg_rdata), .levels(levels)
   );

   nic_arbiter #(.NSRC(NSRC)) u_arb (
      .req(irq_req), .levels(levels), .found(found),
      .win_idx(win_idx), .win_lvl(win_lvl)
   );

   assign qualify = status.ien && found && (win_lvl < status.lvl);
   assign take    = qualify && !st_wr && !irq_ret;
   assign do_pop  = irq_ret && !st_wr;

   nic_stack #(.DEPTH(STACK_DEPTH), .W(1+LW)) u_stack (
      .clk(clk), .rst_n(rst_n), .push(take), .pop(do_pop),
      .din(status), .dout(saved_raw[LW:0]), .depth(nest_depth), .ovf(stack_ovf)
   );
   assign saved_raw[2+LW-1] = 1'b0;
   assign saved = nic_status_t'(saved_raw[LW:0]);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         status.ien <= 1'b0;
         status.lvl <= '1;
      end else if (st_wr) begin
         status.ien <= st_ien;
         status.lvl <= st_lvl;
      end else if (irq_ret) begin
         if (nest_depth != '0)
            status <= saved;
      end else if (take) begin
         status.lvl <= win_lvl;
      end
   end

   assign take_idx   = take ? win_idx : '0;
   assign take_level = take ? win_lvl : '0;
   assign cur_ien    = status.ien;
   assign cur_lvl    = status.lvl;
endmodule

// File: rtl/nic_checker.sv
module nic_checker #(
   parameter int NSRC  = 24,
   parameter int DEPTH = 4,
   parameter int IDXW  = 5,
   parameter int DEPW  = 3
) (
   input logic            clk,
   input logic            rst_n,
   input logic [NSRC-1:0] irq_req,
   input logic            st_wr,
   input logic            irq_ret,
   input logic            take,
   input logic [IDXW-1:0] take_idx,
   input logic [1:0]      take_level,
   input logic            cur_ien,
   input logic [1:0]      cur_lvl,
   input logic [DEPW-1:0] nest_depth,
   input logic            stack_ovf
);
   // R3: a level-3 source never appears as a winner
   a_r3_no_level3: assert property (@(posedge clk) disable iff (!rst_n)
      take |-> take_level != 2'd3);

   // R4: acceptance needs enable and a strictly more urgent level
   a_r4_gate: assert property (@(posedge clk) disable iff (!rst_n)
      take |-> (cur_ien && take_level < cur_lvl));

   // R5: the winner is a pending source
   a_r5_pending: assert property (@(posedge clk) disable iff (!rst_n)
      take |-> irq_req[take_idx]);

   // R6: entry loads the winner's level and keeps enable
   a_r6_entry_level: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> (cur_lvl == $past(take_level) && cur_ien == $past(cur_ien)));

   // R6: entry deepens the stack when room remains
   a_r6_depth_up: assert property (@(posedge clk) disable iff (!rst_n)
      (take && nest_depth < DEPW'(DEPTH)) |=> nest_depth == $past(nest_depth) + DEPW'(1));

   // R7: return with empty stack leaves the status alone
   a_r7_empty_ret: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_ret && !st_wr && nest_depth == '0) |=> ($stable(cur_lvl) && $stable(cur_ien)));

   // R8: overflow flag is sticky and the depth never exceeds the limit
   a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      stack_ovf |=> stack_ovf);
   a_r8_depth_bound: assert property (@(posedge clk) disable iff (!rst_n)
      nest_depth <= DEPW'(DEPTH));

   // R9: no take in a cycle with a status write or a return
   a_r9_no_take_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      (st_wr || irq_ret) |-> !take);

   // R10: level 0 blocks all takes
   a_r10_level0_block: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_lvl == 2'd0) |-> !take);
endmodule

bind nic_top nic_checker #(
   .NSRC(NSRC), .DEPTH(STACK_DEPTH), .IDXW(IDXW), .DEPW(DEPW)
) u_nic_checker (
   .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .st_wr(st_wr),
   .irq_ret(irq_ret), .take(take), .take_idx(take_idx),
   .take_level(take_level), .cur_ien(cur_ien), .cur_lvl(cur_lvl),
   .nest_depth(nest_depth), .stack_ovf(stack_ovf)
);

// File: tb/nic_top_bench.sv
module nic_top_bench;
   logic        clk = 1'b0;
   logic        rst_n;
   logic [2:0]  reg_addr;
   logic        reg_wr;
   logic [7:0]  reg_wdata;
   logic [7:0]  reg_rdata;
   logic [23:0] irq_req;
   logic        st_wr, st_ien, irq_ret;
   logic [1:0]  st_lvl;
   logic        take;
   logic [4:0]  take_idx;
   logic [1:0]  take_level;
   logic        cur_ien;
   logic [1:0]  cur_lvl;
   logic [2:0]  nest_depth;
   logic        stack_ovf;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   nic_top u_nic_top (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_req(irq_req),
      .st_wr(st_wr), .st_ien(st_ien), .st_lvl(st_lvl), .irq_ret(irq_ret),
      .take(take), .take_idx(take_idx), .take_level(take_level),
      .cur_ien(cur_ien), .cur_lvl(cur_lvl), .nest_depth(nest_depth),
      .stack_ovf(stack_ovf)
   );

   // {req[23:0], ien, lvl[1:0], expect_take, expect_idx[4:0]}
   // Source s has level s%4 (every register programmed to 8'hE4).
   localparam logic [32:0] VEC [12] = '{
      {24'h000002, 1'b1, 2'd3, 1'b1, 5'd1 },  // R4 plain take
      {24'h000008, 1'b1, 2'd3, 1'b0, 5'd0 },  // R3 level 3 source
      {24'h000024, 1'b1, 2'd3, 1'b1, 5'd5 },  // R5 lower level wins
      {24'h000220, 1'b1, 2'd3, 1'b1, 5'd5 },  // R5 tie to lowest index
      {24'h000002, 1'b0, 2'd3, 1'b0, 5'd0 },  // R4 enable off
      {24'h000002, 1'b1, 2'd1, 1'b0, 5'd0 },  // R4 equal level blocked
      {24'h000010, 1'b1, 2'd1, 1'b1, 5'd4 },  // R4 level 0 beats 1
      {24'h000010, 1'b1, 2'd0, 1'b0, 5'd0 },  // R10 level 0 blocks
      {24'hFFFFFF, 1'b1, 2'd3, 1'b1, 5'd0 },  // R5 all pending
      {24'hC00000, 1'b1, 2'd3, 1'b1, 5'd22},  // R3 R5 top sources
      {24'hC00000, 1'b1, 2'd2, 1'b0, 5'd0 },  // R4 strictly below
      {24'h000000, 1'b1, 2'd3, 1'b0, 5'd0 }   // R4 nothing pending
   };

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      reg_wr = 1'b0; st_wr = 1'b0; irq_ret = 1'b0; irq_req = '0;
      reg_addr = '0; reg_wdata = '0; st_ien = 1'b0; st_lvl = '0;
      tick(); tick();
      rst_n = 1'b1;
   endtask

   task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      tick();
      reg_wr = 1'b0;
   endtask

   task automatic program_all();
      for (int r = 0; r < 6; r++) wr_reg(3'(r), 8'hE4);
   endtask

   task automatic set_status(input logic e, input logic [1:0] l);
      st_wr = 1'b1; st_ien = e; st_lvl = l;
      tick();
      st_wr = 1'b0;
   endtask

   task automatic ret_pulse();
      irq_ret = 1'b1;
      tick();
      irq_ret = 1'b0;
   endtask

   initial begin
      @(negedge clk);
      do_reset();
      // R1 reset state
      #1;
      check("R1 cur_ien", cur_ien, 0);
      check("R1 cur_lvl", cur_lvl, 3);
      check("R1 depth", nest_depth, 0);
      check("R1 ovf", stack_ovf, 0);
      check("R1 take", take, 0);
      for (int r = 0; r < 6; r++) begin
         reg_addr = 3'(r); #1;
         check("R1 level reg reset", reg_rdata, 8'hFF);
      end
      tick();

      // R2 register access
      wr_reg(3'd2, 8'h1B); reg_addr = 3'd2; #1;
      check("R2 readback", reg_rdata, 8'h1B);
      wr_reg(3'd7, 8'h00); wr_reg(3'd6, 8'h00);
      reg_addr = 3'd6; #1;
      check("R2 addr6 reads 0", reg_rdata, 0);
      for (int r = 0; r < 6; r++) begin
         reg_addr = 3'(r); #1;
         check("R2 no write at 6/7", reg_rdata, (r == 2) ? 8'h1B : 8'hFF);
      end
      // R2 field position: reg2 = 8'h1B gives source 8 level 3, 9 level 2, 10 level 1, 11 level 0
      set_status(1'b1, 2'd3);
      irq_req = 24'h000F00; #1;
      check("R2 field map take", take, 1);
      check("R2 field map idx", take_idx, 11);
      irq_req = '0;
      tick();

      // Vector table
      do_reset();
      program_all();
      foreach (VEC[i]) begin
         set_status(VEC[i][8], VEC[i][7:6]);
         irq_req = VEC[i][32:9]; #1;
         check("R3 R4 R5 R10 take", take, VEC[i][5]);
         if (VEC[i][5]) check("R5 idx", take_idx, VEC[i][4:0]);
         tick();
         irq_req = '0;
      end

      // R6 / R7 nesting and return
      do_reset();
      program_all();
      set_status(1'b1, 2'd3);
      irq_req = 24'h000004; #1;
      check("R6 first take", take, 1);
      tick();
      check("R6 level after entry", cur_lvl, 2);
      check("R6 enable kept", cur_ien, 1);
      check("R6 depth 1", nest_depth, 1);
      #1; check("R6 no retake at own level", take, 0);
      irq_req = 24'h000006; #1;
      check("R6 nested take", take, 1);
      check("R6 nested idx", take_idx, 1);
      tick();
      check("R6 level 1", cur_lvl, 1);
      check("R6 depth 2", nest_depth, 2);
      irq_req = '0;
      ret_pulse();
      check("R7 pop level", cur_lvl, 2);
      check("R7 pop depth", nest_depth, 1);
      ret_pulse();
      check("R7 pop to base", cur_lvl, 3);
      check("R7 enable restored", cur_ien, 1);
      ret_pulse();
      check("R7 empty ret level", cur_lvl, 3);
      check("R7 empty ret depth", nest_depth, 0);

      // R9 strobes suppress take; status write beats return
      irq_req = 24'h000002;
      st_wr = 1'b1; st_ien = 1'b1; st_lvl = 2'd3; #1;
      check("R9 no take on status write", take, 0);
      tick(); st_wr = 1'b0; #1;
      check("R9 take after write", take, 1);
      tick();
      irq_req = 24'h000012; irq_ret = 1'b1; #1;
      check("R9 no take on return", take, 0);
      tick(); irq_ret = 1'b0;
      check("R7 restored level", cur_lvl, 3);
      #1; check("R9 take after return idx", take_idx, 4);
      tick();
      st_wr = 1'b1; st_ien = 1'b1; st_lvl = 2'd2; irq_ret = 1'b1;
      tick(); st_wr = 1'b0; irq_ret = 1'b0; irq_req = '0;
      check("R9 write beats return lvl", cur_lvl, 2);
      check("R9 write beats return depth", nest_depth, 1);

      // R8 overflow
      do_reset();
      program_all();
      irq_req = 24'h000002;
      for (int k = 0; k < 5; k++) begin
         set_status(1'b1, (k % 2 == 1) ? 2'd2 : 2'd3);
         #1; check("R8 take while filling", take, 1);
         tick();
         check("R8 depth", nest_depth, (k < 4) ? k + 1 : 4);
         check("R8 ovf", stack_ovf, (k == 4) ? 1 : 0);
         check("R8 status still updated", cur_lvl, 1);
      end
      irq_req = '0;
      for (int j = 0; j < 4; j++) begin
         ret_pulse();
         check("R8 entries intact", cur_lvl, (j % 2 == 0) ? 2 : 3);
         check("R8 depth on pop", nest_depth, 3 - j);
         check("R8 ovf sticky", stack_ovf, 1);
      end

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(20 * 200000);
      errors++;
      $display("FAIL watchdog actual hung expected done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule